// File: doc/BRIEF.md
# Tracking Speed Memory Register

This block keeps the cruise set speed as a 9-bit code that feeds an external resistor-ladder DAC. The stored value is not loaded in parallel. A store request starts a search. On the next oscillator tick the code is cleared to zero. After that the code climbs by one step per tick for as long as an external comparator reports that the DAC output is still below the measured vehicle speed. The search ends when the comparator stops reporting "below", or when the code reaches the ceiling that stands for the highest storable speed. The block then raises a done flag and holds the code.

The surrounding control logic issues a store each time the driver releases an accelerate or coast command. It issues an erase at power-up or when the system is switched off. Erase wins over store and zeroes the code at the next clock edge, whether or not a tick is present. One code step is about 0.45 mph, and the default ceiling code of 222 corresponds to roughly 100 mph.

Top module: `spdmem_track`

## Requirements
- R1: While `rst_n` is low, and at the first edge after reset, `code_o` is 0 and `done_o` is 0.
- R2: A store request (`store_req`=1, `erase_req`=0) sampled at an edge drops `done_o` to 0 and leaves the code unchanged. The first later edge that has `tick_en`=1 clears the code to 0.
- R3: During a search, each edge with `tick_en`=1 and `below_i`=1 raises `code_o` by exactly one, provided the code is below the ceiling.
- R4: During a search, an edge with `tick_en`=1 and `below_i`=0 ends the search. The code is kept and `done_o` becomes 1 after that edge.
- R5: When the code equals `CEIL_CODE` (default 222), the next ticked search edge ends the search with `done_o`=1 and the code left at `CEIL_CODE`, even though `below_i` is still 1. The code never exceeds `CEIL_CODE`.
- R6: An edge with `tick_en`=0 and `erase_req`=0 never changes `code_o`.
- R7: A store request that arrives during a search or a pending clear restarts the sequence. The next tick clears the code to 0 and counting begins again from there.
- R8: `erase_req`=1 at an edge forces `code_o` to 0 and `done_o` to 0 after that edge, without needing a tick. A store requested in the same cycle is ignored, so later ticks leave the code at 0.
- R9: Once `done_o` is 1, ticks and changes of `below_i` leave the code and the flag unchanged until the next store or erase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset; also erases the code |
| tick_en | input | 1 | One-cycle oscillator tick that allows one search step |
| store_req | input | 1 | Start a new clear-then-count search |
| erase_req | input | 1 | Zero the code and abandon any search (priority over store) |
| below_i | input | 1 | Comparator: DAC output is still below the speed voltage |
| code_o | output | 9 | Code driving the ladder DAC |
| done_o | output | 1 | High once a search has finished, until the next store or erase |

## Verification
The search is exercised with the comparator tripping after a few steps, with the comparator never tripping so the count runs into the ceiling, and with tick gaps inside a search. Together these separate a correct stop on the comparator from a stop on the ceiling, and show that no step is taken without a tick. Store requests are also issued in the middle of a search and while a nonzero code is held. These show that the clear waits for a tick and that a restart always begins from zero. Erase is applied alone, and together with store, to show its priority and that it does not wait for a tick.

// File: rtl/spdmem_pkg.sv
package spdmem_pkg;

   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_CLEAR  = 2'd1,
      ST_SEARCH = 2'd2,
      ST_HOLD   = 2'd3
   } spd_state_t;

endpackage

// File: rtl/spdmem_cmpin.sv
module spdmem_cmpin #(
   parameter int SYNC_STAGES = 0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic raw_i,
   output logic cond_o
);

   if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
      $error("spdmem_cmpin: SYNC_STAGES must be in 0..4");
   end

   if (SYNC_STAGES == 0) begin : g_direct
      assign cond_o = raw_i;
   end else begin : g_sync
      logic [SYNC_STAGES-1:0] pipe_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) pipe_q <= '0;
         else        pipe_q <= {pipe_q[SYNC_STAGES-1:0], raw_i} >> 0;
      end
      assign cond_o = pipe_q[SYNC_STAGES-1];
   end

endmodule

// File: rtl/spdmem_cnt.sv
module spdmem_cnt #(
   parameter int WIDTH = 9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr_i,
   input  logic             inc_i,
   output logic [WIDTH-1:0] code_o
);

   localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

   logic [WIDTH-1:0] code_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     code_q <= '0;
      else if (clr_i) code_q <= '0;
      else if (inc_i) code_q <= code_q + ONE;
   end

   assign code_o = code_q;

endmodule

// File: rtl/spdmem_seq.sv
module spdmem_seq
   import spdmem_pkg::*;
#(
   parameter int WIDTH     = 9,
   parameter int CEIL_CODE = 222
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_en,
   input  logic             store_req,
   input  logic             erase_req,
   input  logic             below_i,
   input  logic [WIDTH-1:0] code_i,
   output logic             clr_o,
   output logic             inc_o,
   output logic             done_o
);

   localparam logic [WIDTH-1:0] CEIL = WIDTH'(CEIL_CODE);

   spd_state_t state_q, state_d;
   logic       done_q, done_d;
   logic       at_ceil;

   assign at_ceil = (code_i >= CEIL);

   always_comb begin
      state_d = state_q;
      done_d  = done_q;
      clr_o   = 1'b0;
      inc_o   = 1'b0;
      if (erase_req) begin
         state_d = ST_IDLE;
         done_d  = 1'b0;
         clr_o   = 1'b1;
      end else if (store_req) begin
         state_d = ST_CLEAR;
         done_d  = 1'b0;
      end else if (tick_en) begin
         case (state_q)
            ST_CLEAR: begin
               clr_o   = 1'b1;
               state_d = ST_SEARCH;
            end
            ST_SEARCH: begin
               if (below_i && !at_ceil) begin
                  inc_o = 1'b1;
               end else begin
                  state_d = ST_HOLD;
                  done_d  = 1'b1;
               end
            end
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         done_q  <= 1'b0;
      end else begin
         state_q <= state_d;
         done_q  <= done_d;
      end
   end

   assign done_o = done_q;

   AST_CODE_CEIL: assert property (@(posedge clk) disable iff (!rst_n)
      code_i <= CEIL); // R5

   AST_ERASE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      erase_req |=> (code_i == '0 && !done_q)); // R8

   AST_NO_TICK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick_en && !erase_req) |=> $stable(code_i)); // R6

   AST_SINGLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(code_i) |-> (code_i == '0 || code_i == $past(code_i) + WIDTH'(1))); // R3

   AST_DONE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      (done_q && !store_req && !erase_req) |=> (done_q && $stable(code_i))); // R9

endmodule

// File: rtl/spdmem_track.sv
module spdmem_track #(
   parameter int WIDTH       = 9,
   parameter int CEIL_CODE   = 222,
   parameter int SYNC_STAGES = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_en,
   input  logic             store_req,
   input  logic             erase_req,
   input  logic             below_i,
   output logic [WIDTH-1:0] code_o,
   output logic             done_o
);

   if (WIDTH < 2 || WIDTH > 16) begin : g_bad_width
      $error("spdmem_track: WIDTH must be in 2..16");
   end
   if (CEIL_CODE < 1 || CEIL_CODE >= (1 << WIDTH)) begin : g_bad_ceil
      $error("spdmem_track: CEIL_CODE must fit in WIDTH bits and be nonzero");
   end

   logic             below_c;
   logic             clr_w, inc_w;
   logic [WIDTH-1:0] code_w;

   spdmem_cmpin #(.SYNC_STAGES(SYNC_STAGES)) u_cmpin (
      .clk    (clk),
      .rst_n  (rst_n),
      .raw_i  (below_i),
      .cond_o (below_c)
   );

   spdmem_seq #(.WIDTH(WIDTH), .CEIL_CODE(CEIL_CODE)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick_en   (tick_en),
      .store_req (store_req),
      .erase_req (erase_req),
      .below_i   (below_c),
      .code_i    (code_w),
      .clr_o     (clr_w),
      .inc_o     (inc_w),
      .done_o    (done_o)
   );

   spdmem_cnt #(.WIDTH(WIDTH)) u_cnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr_i  (clr_w),
      .inc_i  (inc_w),
      .code_o (code_w)
   );

   assign code_o = code_w;

endmodule

// File: tb/spdmem_track_test.sv
module spdmem_track_test;

   localparam int W    = 9;
   localparam int CEIL = 222;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         tick_en = 1'b0, store_req = 1'b0, erase_req = 1'b0, below_i = 1'b0;
   logic [W-1:0] code_o;
   logic         done_o;

   int checks = 0;
   int fails  = 0;

   typedef struct {
      logic [W-1:0] code;
      logic         done;
      string        tag;
   } exp_t;

   exp_t exp_q[$];

   int           m_st   = 0;   // 0 idle, 1 clear pending, 2 search, 3 hold
   logic [W-1:0] m_code = '0;
   logic         m_done = 1'b0;

   always #5 clk = ~clk;

   spdmem_track uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick_en   (tick_en),
      .store_req (store_req),
      .erase_req (erase_req),
      .below_i   (below_i),
      .code_o    (code_o),
      .done_o    (done_o)
   );

   task automatic compare(input logic [W-1:0] c, input logic d, input string tag);
      checks++;
      if (code_o !== c || done_o !== d) begin
         fails++;
         $display("FAIL %s: code=%0d done=%0b expected code=%0d done=%0b",
                  tag, code_o, done_o, c, d);
      end
   endtask

   task automatic step(input logic t, input logic s, input logic e, input logic b,
                       input string tag);
      exp_t it;
      @(negedge clk);
      tick_en = t; store_req = s; erase_req = e; below_i = b;
      if (e) begin
         m_code = '0; m_done = 1'b0; m_st = 0;
      end else if (s) begin
         m_st = 1; m_done = 1'b0;
      end else if (t) begin
         if (m_st == 1) begin
            m_code = '0; m_st = 2;
         end else if (m_st == 2) begin
            if (b && m_code < CEIL) m_code = m_code + 1'b1;
            else begin m_st = 3; m_done = 1'b1; end
         end
      end
      it.code = m_code; it.done = m_done; it.tag = tag;
      exp_q.push_back(it);
   endtask

   initial begin : monitor
      exp_t it;
      forever begin
         @(posedge clk);
         #1;
         if (exp_q.size() > 0) begin
            it = exp_q.pop_front();
            compare(it.code, it.done, it.tag);
         end
      end
   end

   initial begin : watchdog
      #2000000;
      fails++;
      $display("FAIL watchdog: run hung, actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin : driver
      repeat (3) @(posedge clk);
      #1;
      compare('0, 1'b0, "R1 during reset");
      @(negedge clk);
      rst_n = 1'b1;
      step(0, 0, 0, 0, "R1 first edge after reset");

      // R2 / R3 / R4: search stopping on the comparator at 5
      step(0, 1, 0, 1, "R2 store alone");
      step(1, 0, 0, 1, "R2 clear on tick");
      for (int i = 0; i < 5; i++) step(1, 0, 0, 1, "R3 increment");
      step(1, 0, 0, 0, "R4 comparator stop");
      // R9: held after done
      step(1, 0, 0, 1, "R9 tick ignored after done");
      step(1, 0, 0, 0, "R9 below change ignored");
      step(0, 0, 0, 1, "R9 idle cycle");

      // R2: store keeps old code until tick; R6 gaps inside a search
      step(0, 1, 0, 1, "R2 store holds old code");
      step(0, 0, 0, 1, "R6 no tick before clear");
      step(1, 0, 0, 1, "R2 clear to zero");
      step(1, 0, 0, 1, "R3 step");
      step(0, 0, 0, 1, "R6 gap");
      step(0, 0, 0, 0, "R6 gap with below low");
      step(1, 0, 0, 1, "R3 step after gap");
      step(1, 0, 0, 1, "R3 step");
      // R7: restart mid search
      step(1, 1, 0, 1, "R7 store during search");
      step(1, 0, 0, 1, "R7 restart clears");
      step(1, 0, 0, 1, "R7 count from zero");
      step(1, 0, 0, 1, "R7 count");
      step(1, 0, 0, 0, "R4 stop at 2");

      // R5: comparator never trips, run into the ceiling
      step(0, 1, 0, 1, "R5 store");
      step(1, 0, 0, 1, "R5 clear");
      for (int i = 0; i < CEIL; i++) step(1, 0, 0, 1, "R5 climb");
      step(1, 0, 0, 1, "R5 ceiling stop");
      step(1, 0, 0, 1, "R5 stays at ceiling");

      // R8: erase without tick, and erase beating store
      step(0, 0, 1, 1, "R8 erase no tick");
      step(1, 0, 0, 1, "R8 idle after erase");
      step(0, 1, 0, 1, "R8 store");
      step(1, 0, 0, 1, "R8 clear");
      step(1, 0, 0, 1, "R8 count");
      step(1, 0, 0, 1, "R8 count");
      step(0, 1, 1, 1, "R8 erase with store");
      step(1, 0, 0, 1, "R8 store ignored tick");
      step(1, 0, 0, 1, "R8 store ignored tick");
      step(0, 0, 0, 0, "R8 quiet");

      repeat (3) @(posedge clk);
      #2;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule